// File: doc/BRIEF.md
# Instruction Skip Mask Sequencer

This block sits in a processor's fetch path and decides which instruction address is issued on each clock. Software loads a bit mask with a skip command. Each mask bit, least significant first, marks one upcoming sequential instruction as executed (bit clear) or suppressed (bit set). The mask advances by one position for every instruction passed, whether that instruction is issued or skipped.

The block does not cancel suppressed instructions one at a time in the pipeline. An eight-bit window at the bottom of the mask feeds a trailing-ones encoder. The fetch address then leaps over up to seven set bits in the same cycle that issues the next executed instruction. When the whole window is set, eight positions are consumed in one leap, and that leap costs a fixed number of idle fetch cycles.

A skip command whose condition field carries the implied-return code redirects fetch to the return address, and the new mask applies from there. A taken branch abandons the mask. Interrupts are held off while a mask is still pending.

Top module: `skip_mask_seq`

## Requirements
- R1: While reset is asserted, fetch_addr equals RESET_ADDR (0), fetch_vld is 1, and stall, skip_active and irq_ok are 0.
- R2: When no mask is pending, one instruction is issued every clock at consecutive addresses.
- R3: Bit 0 of a loaded mask governs the first instruction fetched after the load. A set bit skips that instruction and a clear bit issues it. The mask moves on by one bit for each instruction passed.
- R4: A run of up to seven set bits followed by a clear bit is leapt over in one cycle. The next executed instruction issues in the cycle directly after the previous one.
- R5: Each complete group of eight set bits in a run costs PENALTY (2) cycles in which fetch_vld is 0 and stall is 1. Fetching then resumes eight addresses further on.
- R6: If sk_cond equals 4'b0000 (implied return) when sk_go is high, fetch continues from ret_addr and the new mask applies there. Any other sk_cond value continues sequentially.
- R7: skip_active is 1 while any mask bit remains and falls to 0 once the mask is used up.
- R8: A taken branch (br_taken without sk_go) discards the mask and issues br_addr in the next cycle.
- R9: A skip command while a mask is pending, including during a penalty stall, replaces the old mask completely.
- R10: irq_ok follows irq_req while no mask is pending, and is 0 while skip_active is 1.
- R11: When sk_go and br_taken are high in the same cycle, the skip command wins and the branch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sk_go | input | 1 | Skip command executes this cycle |
| sk_mask | input | MASK_W (23) | Mask: bit set means skip the corresponding instruction |
| sk_cond | input | 4 | Condition field of the skip command; 4'b0000 means implied return |
| ret_addr | input | ADDR_W (16) | Return address used with an implied return |
| br_taken | input | 1 | Another branch redirects fetch |
| br_addr | input | ADDR_W (16) | Branch target |
| irq_req | input | 1 | Interrupt request |
| fetch_addr | output | ADDR_W (16) | Address issued this cycle |
| fetch_vld | output | 1 | fetch_addr is an issued instruction |
| stall | output | 1 | Penalty cycle, nothing issued |
| skip_active | output | 1 | Mask bits are still pending |
| irq_ok | output | 1 | Interrupt may be taken |

## Verification
The bench targets the run lengths at the encoder boundary: 7, 8, 9, 16 and 23 set bits, plus scattered patterns. It compares every issued address and its cycle index against a model that counts runs independently. An encoder off by one would issue a skipped address or lose one, and a wrong penalty would move every later instruction by a cycle. It also loads a mask together with an implied return, a taken branch and a replacement during a stall. A design that applied the mask at the old address, let the branch win, or kept stale mask bits would issue the wrong addresses there.

// File: rtl/skseq_pkg.sv
// Package: shared constants, slot kinds and condition decode for the
// skip mask sequencer. Assumes a 4-bit condition field.
package skseq_pkg;

    localparam int COND_W = 4;
    // Condition value that carries an implied return (cannot be a no-op).
    localparam logic [COND_W-1:0] COND_IMPLIED_RET = 4'b0000;

    // What the fetch slot does in the current cycle.
    typedef enum logic [1:0] {
        SLOT_ISSUE = 2'd0,   // an instruction address is issued
        SLOT_LEAP  = 2'd1,   // a full window of set bits is consumed
        SLOT_WAIT  = 2'd2    // remaining penalty cycle
    } slot_e;

    function automatic logic cond_is_ret(input logic [COND_W-1:0] c);
        return c == COND_IMPLIED_RET;
    endfunction

endpackage

// File: rtl/skseq_run_enc.sv
// Trailing-ones encoder: counts consecutive set bits from bit 0 of the
// window and flags a window that is set throughout. Assumes WIN >= 2.
module skseq_run_enc #(
    parameter int WIN = 8,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic [WIN-1:0] win,
    output logic [CW-1:0]  run_len,
    output logic           full
);

    logic [WIN-1:0] pre;

    // Prefix-AND chain: pre[i] is set when bits 0..i are all set.
    genvar i;
    generate
        for (i = 0; i < WIN; i++) begin : g_pre
            if (i == 0) begin : g_first
                assign pre[i] = win[i];
            end else begin : g_rest
                assign pre[i] = pre[i-1] & win[i];
            end
        end
    endgenerate

    // Population count of the prefix gives the run length.
    always_comb begin
        run_len = '0;
        for (int k = 0; k < WIN; k++) begin
            run_len = run_len + CW'(pre[k]);
        end
    end

    assign full = pre[WIN-1];

endmodule

// File: rtl/skseq_penalty.sv
// Penalty counter: after a full-window leap, holds busy for the remaining
// PENALTY-1 cycles. A clear (redirect) cancels the wait at once.
module skseq_penalty #(
    parameter int PENALTY = 2,
    localparam int CNT_W = $clog2(PENALTY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fire,
    output logic busy
);

    logic [CNT_W-1:0] cnt_q;

    // Load, count down or clear the remaining wait cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= CNT_W'(PENALTY - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/skip_mask_seq.sv
// Skip mask sequencer: holds the fetch PC and the pending skip mask,
// issues one address per clock, leaps runs of set bits through an
// 8-bit trailing-ones window and stalls PENALTY cycles per full window.
// Assumes MASK_W >= WIN and that a skip command or branch is presented
// for one cycle and takes effect at the next edge.
module skip_mask_seq
    import skseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MASK_W     = 23,
    parameter int WIN        = 8,
    parameter int PENALTY    = 2,
    parameter int RESET_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sk_go,
    input  logic [MASK_W-1:0] sk_mask,
    input  logic [COND_W-1:0] sk_cond,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic              irq_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_vld,
    output logic              stall,
    output logic              skip_active,
    output logic              irq_ok
);

    localparam int CW = $clog2(WIN + 1);

    logic [ADDR_W-1:0] pc_q;
    logic [MASK_W-1:0] mask_q;
    logic [CW-1:0]     run_len;
    logic              win_full;
    logic              pen_busy;
    logic              pen_fire;
    logic              redirect;
    slot_e             slot;
    logic [CW:0]       adv;
    logic [MASK_W-1:0] mask_adv;
    logic [ADDR_W-1:0] pc_seq;

    skseq_run_enc #(.WIN(WIN)) u_enc (
        .win     (mask_q[WIN-1:0]),
        .run_len (run_len),
        .full    (win_full)
    );

    // Slot decision: finish a penalty, leap a full window, or issue.
    always_comb begin
        if (pen_busy) begin
            slot = SLOT_WAIT;
        end else if (win_full) begin
            slot = SLOT_LEAP;
        end else begin
            slot = SLOT_ISSUE;
        end
    end

    // Step size and remaining mask for the chosen slot.
    always_comb begin
        unique case (slot)
            SLOT_ISSUE: begin
                adv      = {1'b0, run_len} + {{CW{1'b0}}, 1'b1};
                mask_adv = mask_q >> adv;
            end
            SLOT_LEAP: begin
                adv      = (CW+1)'(WIN);
                mask_adv = mask_q >> WIN;
            end
            default: begin
                adv      = '0;
                mask_adv = mask_q;
            end
        endcase
    end

    assign pc_seq   = pc_q + ADDR_W'(adv);
    assign redirect = sk_go | br_taken;
    assign pen_fire = (slot == SLOT_LEAP) && !redirect;

    skseq_penalty #(.PENALTY(PENALTY)) u_pen (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (redirect),
        .fire  (pen_fire),
        .busy  (pen_busy)
    );

    // PC and mask update: skip command first, then branch, then stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= ADDR_W'(RESET_ADDR);
            mask_q <= '0;
        end else if (sk_go) begin
            mask_q <= sk_mask;
            pc_q   <= cond_is_ret(sk_cond) ? ret_addr : pc_seq;
        end else if (br_taken) begin
            mask_q <= '0;
            pc_q   <= br_addr;
        end else begin
            mask_q <= mask_adv;
            pc_q   <= pc_seq;
        end
    end

    assign fetch_addr  = pc_q + ADDR_W'(run_len);
    assign fetch_vld   = (slot == SLOT_ISSUE);
    assign stall       = !fetch_vld;
    assign skip_active = |mask_q;
    assign irq_ok      = irq_req && !skip_active;

endmodule

// File: rtl/skip_mask_seq_chk.sv
// Checker for skip_mask_seq: temporal properties on the ports, bound
// into every instance of the top module.
module skip_mask_seq_chk
    import skseq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int MASK_W  = 23,
    parameter int PENALTY = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sk_go,
    input logic [MASK_W-1:0] sk_mask,
    input logic [COND_W-1:0] sk_cond,
    input logic [ADDR_W-1:0] ret_addr,
    input logic              br_taken,
    input logic [ADDR_W-1:0] br_addr,
    input logic              irq_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_vld,
    input logic              stall,
    input logic              skip_active,
    input logic              irq_ok
);

    // R2: without a mask, the next address follows the last one.
    p_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld && !skip_active && !sk_go && !br_taken
        |=> fetch_vld && (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)));

    // R7, R10: a nonzero mask makes skip_active rise and blocks interrupts.
    p_load_blocks_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sk_go && (sk_mask != '0) |=> skip_active && !irq_ok);

    // R10: an interrupt is only allowed when one is requested.
    p_irq_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ok |-> irq_req);

    // R6: implied return with bit 0 clear issues the return address next.
    p_implied_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sk_go && (sk_cond == COND_IMPLIED_RET) && !sk_mask[0]
        |=> fetch_vld && (fetch_addr == $past(ret_addr)));

    // R8: a lone branch clears the mask and issues its target.
    p_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken && !sk_go
        |=> fetch_vld && !skip_active && (fetch_addr == $past(br_addr)));

    // R5: a penalty lasts longer than one cycle when PENALTY > 1.
    generate
        if (PENALTY > 1) begin : g_pen
            p_penalty_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
                stall && !$past(stall) && !sk_go && !br_taken |=> stall);
        end
    endgenerate

endmodule

bind skip_mask_seq skip_mask_seq_chk #(
    .ADDR_W  (ADDR_W),
    .MASK_W  (MASK_W),
    .PENALTY (PENALTY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sk_go       (sk_go),
    .sk_mask     (sk_mask),
    .sk_cond     (sk_cond),
    .ret_addr    (ret_addr),
    .br_taken    (br_taken),
    .br_addr     (br_addr),
    .irq_req     (irq_req),
    .fetch_addr  (fetch_addr),
    .fetch_vld   (fetch_vld),
    .stall       (stall),
    .skip_active (skip_active),
    .irq_ok      (irq_ok)
);

// File: tb/sim_skip_mask_seq.sv
`timescale 1ns/1ps
// Directed bench for skip_mask_seq: one task per scenario, each checking
// its own results against values derived from the requirements.
module sim_skip_mask_seq;

    localparam int PEN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sk_go = 1'b0;
    logic [22:0] sk_mask = '0;
    logic [3:0]  sk_cond = 4'hF;
    logic [15:0] ret_addr = '0;
    logic        br_taken = 1'b0;
    logic [15:0] br_addr = '0;
    logic        irq_req = 1'b0;
    logic [15:0] fetch_addr;
    logic        fetch_vld;
    logic        stall;
    logic        skip_active;
    logic        irq_ok;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    skip_mask_seq u0 (
        .clk (clk), .rst_n (rst_n), .sk_go (sk_go), .sk_mask (sk_mask),
        .sk_cond (sk_cond), .ret_addr (ret_addr), .br_taken (br_taken),
        .br_addr (br_addr), .irq_req (irq_req), .fetch_addr (fetch_addr),
        .fetch_vld (fetch_vld), .stall (stall), .skip_active (skip_active),
        .irq_ok (irq_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present a skip command for one cycle; returns after the edge.
    task automatic skip_cmd(input logic [22:0] m, input logic [3:0] c,
                            input logic [15:0] ra);
        sk_go = 1'b1; sk_mask = m; sk_cond = c; ret_addr = ra;
        @(negedge clk);
        sk_go = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 addr", fetch_addr, 0);
        chk("R1 vld", fetch_vld, 1);
        chk("R1 stall", stall, 0);
        chk("R1 active", skip_active, 0);
        chk("R1 irq_ok", irq_ok, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sequential;
        int prev;
        prev = fetch_addr;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 seq addr", fetch_addr, (prev + 1) & 16'hFFFF);
            chk("R2 seq vld", fetch_vld, 1);
            prev = fetch_addr;
        end
    endtask

    // Loads a mask with implied return at base; compares issued addresses
    // and their cycle indices with a run-counting model.
    task automatic t_trace(input logic [22:0] m, input int base);
        int ea[10]; int ec[10]; int oa[40]; int oc[40];
        int n = 0; int stalls = 0; int pen_exp = 0;
        int pos = 0; int run = 0; int cyc = 0; int k = 0;
        while (k < 10 || pos <= 23) begin
            if (pos < 23 && m[pos]) begin
                run++;
            end else begin
                cyc += (run / 8) * PEN;
                pen_exp += (run / 8) * PEN;
                if (k < 10) begin ea[k] = base + pos; ec[k] = cyc; end
                cyc++; k++; run = 0;
            end
            pos++;
        end
        skip_cmd(m, 4'b0000, 16'(base));
        chk("R7 active after load", skip_active, (m != 0) ? 1 : 0);
        for (int c = 0; c < 40; c++) begin
            if (fetch_vld) begin oa[n] = fetch_addr; oc[n] = c; n++; end
            if (stall) stalls++;
            @(negedge clk);
        end
        for (int j = 0; j < 10; j++) begin
            chk("R3 R4 R6 trace addr", oa[j], ea[j] & 16'hFFFF);
            chk("R4 R5 trace cycle", oc[j], ec[j]);
        end
        chk("R5 stall cycles", stalls, pen_exp);
        chk("R7 drained", skip_active, 0);
    endtask

    task automatic t_no_return;
        int a;
        a = fetch_addr;
        sk_go = 1'b1; sk_mask = 23'h1; sk_cond = 4'hF; ret_addr = 16'h0300;
        @(negedge clk);
        sk_go = 1'b0;
        chk("R6 R3 sequential skip", fetch_addr, (a + 2) & 16'hFFFF);
        @(negedge clk);
        chk("R7 mask used up", skip_active, 0);
        chk("R3 after skip", fetch_addr, (a + 3) & 16'hFFFF);
    endtask

    task automatic t_branch;
        skip_cmd(23'h7FFFFE, 4'b0000, 16'h0100);
        chk("R6 first addr", fetch_addr, 16'h0100);
        br_taken = 1'b1; br_addr = 16'h0200;
        @(negedge clk);
        br_taken = 1'b0;
        chk("R8 target", fetch_addr, 16'h0200);
        chk("R8 vld", fetch_vld, 1);
        chk("R8 cleared", skip_active, 0);
        @(negedge clk);
        chk("R8 follow", fetch_addr, 16'h0201);
    endtask

    task automatic t_replace;
        skip_cmd(23'h7FFFFF, 4'b0000, 16'h0400);
        chk("R5 stall on full window", stall, 1);
        skip_cmd(23'h000002, 4'b0000, 16'h0500);
        chk("R9 new base", fetch_addr, 16'h0500);
        chk("R9 no stall", stall, 0);
        @(negedge clk);
        chk("R9 new mask", fetch_addr, 16'h0502);
        @(negedge clk);
        chk("R9 old mask gone", skip_active, 0);
        chk("R9 follow", fetch_addr, 16'h0503);
    endtask

    task automatic t_irq;
        irq_req = 1'b1;
        #1;
        chk("R10 idle allows", irq_ok, 1);
        skip_cmd(23'h00FF00, 4'b0000, 16'h0800);
        chk("R10 blocked", irq_ok, 0);
        repeat (30) @(negedge clk);
        chk("R10 allowed after drain", irq_ok, 1);
        irq_req = 1'b0;
        #1;
        chk("R10 follows request", irq_ok, 0);
    endtask

    task automatic t_simultaneous;
        sk_go = 1'b1; sk_mask = 23'h4; sk_cond = 4'b0000; ret_addr = 16'h0600;
        br_taken = 1'b1; br_addr = 16'h0700;
        @(negedge clk);
        sk_go = 1'b0; br_taken = 1'b0;
        chk("R11 skip wins", fetch_addr, 16'h0600);
        chk("R11 mask kept", skip_active, 1);
        @(negedge clk);
        chk("R11 next", fetch_addr, 16'h0601);
        @(negedge clk);
        chk("R11 skip applied", fetch_addr, 16'h0603);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sequential();
        t_trace(23'h000000, 16'h1000);
        t_trace(23'h000015, 16'h1100);
        t_trace(23'h00007F, 16'h1200);
        t_trace(23'h0000FF, 16'h1300);
        t_trace(23'h0001FF, 16'h1400);
        t_trace(23'h00FFFF, 16'h1500);
        t_trace(23'h7FFFFF, 16'h1600);
        t_trace(23'h5A5A5A, 16'h1700);
        t_trace(23'h3FBF7E, 16'h1800);
        t_no_return();
        t_branch();
        t_replace();
        t_irq();
        t_simultaneous();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            finish_run();
        end
    end

endmodule